// File: doc/BRIEF.md
# Smart Card Character Engine

This block moves single characters over the half-duplex I/O line of a contact smart card. Time on the line is measured in elementary time units (ETU), and an external divider supplies a one-cycle pulse four times per ETU. Each character is a low start bit, eight data bits sent least significant bit first, and an even parity bit. The receiver finds the start bit, samples every bit in the middle of its ETU and checks the parity. It then handles the character in one of two protocol modes. In the character-repeat mode (T=0) a bad character is refused with a low pulse on the line and the card sends it again. In the block mode (T=1) a bad character is kept and flagged.

Good characters go into a receive FIFO. The host reads them from a show-ahead port. The transmitter sends one character per request. In T=0 it watches for the card's refusal pulse, sends the character again after each refusal, and gives up after a set number of tries. Four sticky flags report parity failure, overrun, framing error and FIFO threshold. A single status-read strobe clears all four. The interrupt line is high while any flag is set.

The receiver FSM has five states. RX_IDLE goes to RX_START on a low line sample. RX_START goes back to RX_IDLE if the sample at half an ETU is high, and goes on to RX_BITS if it is still low. RX_BITS goes to RX_STOP after the parity sample. RX_STOP goes to RX_IDLE at the commit instant, or to RX_NAK when a T=0 parity failure must be refused. RX_NAK goes to RX_IDLE once the refusal pulse ends.

The transmitter FSM has five states. TX_IDLE goes to TX_ARM on an accepted request. TX_ARM goes to TX_SEND on the next quarter tick. TX_SEND goes to TX_GUARD once the line is released. TX_GUARD goes to TX_IDLE when there is no refusal, or to TX_HOLD when there is one. TX_HOLD goes back to TX_SEND to resend the character, or to TX_IDLE when the attempts are used up.

Top module: `sc_char_engine`

## Requirements
- R1: Timing is counted in quarter ETUs, where n=0 is the quarter tick that first sees the line low. Bits are sampled at n=2, 6, 10 … 38: the start bit first, then data bit 0 up to data bit 7, then parity. Parity is even, so the data bits and the parity bit together hold an even number of ones. The character is committed at n=42 (10.5 ETU). Good characters come out of `rd_data` in arrival order, and `rd_pop` removes the head.
- R2: If the line is high again at n=2, the start is abandoned. Nothing is stored and no flag is set.
- R3: In T=0 (`proto_t1`=0), a received character with a parity failure is not stored. The block drives `io_low` high from n=42 until n=46, which signals a refusal to the card.
- R4: In T=0 reception, the parity flag is set at n=42 when the count of consecutive failed characters reaches `err_limit` (a limit of 0 acts as 1). The count clears after a good character and after the flag is raised.
- R5: In T=1, a character with a parity failure is still stored, and the parity flag is set at its commit.
- R6: The framing flag is set when the line is low at n=41 (10.25 ETU).
- R7: The threshold flag is set when a stored character raises the FIFO count to `ft_thr`+1.
- R8: A character that commits while the FIFO holds `DEPTH` entries is dropped, and the overrun flag is set. This holds even if a pop happens in the same cycle.
- R9: `status` bits are threshold [0], framing [1], overrun [2] and parity [3]. Reset clears all of them. A flag stays set until a cycle with `stat_rd` high clears it. A new event in that same cycle wins over the clear.
- R10: `irq` is high exactly while at least one status bit is set.
- R11: `tx_go` is taken only while both directions are idle. Sending starts at the next quarter tick, which is n=0. Frame bit k (start, data 0..7, parity) is driven during n=4k..4k+3. The line is released at n=40. `tx_busy` falls at n=42 unless a refusal is seen.
- R12: In T=0 a low line at n=42 of a transmitted frame counts as a refusal. After a refusal the frame is sent again from n=48. On the (`err_limit`+1)th refusal the parity flag is set at n=46 and the character is dropped.
- R13: The receiver ignores the line while `tx_busy` is high, so the block's own frames and the card's refusals are never stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| qtick | input | 1 | One-cycle pulse, four per ETU |
| proto_t1 | input | 1 | 1 = block mode (T=1), 0 = character-repeat mode (T=0) |
| err_limit | input | 3 | Parity retry limit |
| ft_thr | input | THR_W | FIFO threshold value |
| io_in | input | 1 | Synchronized level of the I/O line |
| io_low | output | 1 | Pull the I/O line low (open drain) |
| tx_go | input | 1 | Request to send `tx_data` |
| tx_data | input | 8 | Character to send |
| tx_busy | output | 1 | Transmitter active |
| rd_pop | input | 1 | Remove the FIFO head |
| rd_data | output | 8 | FIFO head character |
| fifo_count | output | $clog2(DEPTH+1) | Number of stored characters |
| stat_rd | input | 1 | Status read strobe, clears the flags |
| status | output | 4 | Sticky flags: pe, ovr, fer, ft |
| irq | output | 1 | OR of all status flags |

## Verification
The bench builds the block with DEPTH=4 and THR_W=5. The small FIFO fills after four characters, so a fifth character shows the overrun drop within a short run, and a threshold of 1 makes the threshold flag rise on the second character. The bench drives the card side of the line at quarter-tick resolution. This lets it place a framing fault at exactly 10.25 ETU and refusal pulses at 10.5 ETU. The retry limit is set to 1 for transmission and 2 for reception, so both the resend path and the give-up path are reached.

// File: rtl/sc_pkg.sv
package sc_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_STOP,
        RX_NAK
    } rx_state_t;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_ARM,
        TX_SEND,
        TX_GUARD,
        TX_HOLD
    } tx_state_t;

    // quarter-ETU instants counted from start detection
    localparam logic [5:0] Q_START_CHK = 6'd2;
    localparam logic [5:0] Q_PAR_SMP   = 6'd38;
    localparam logic [5:0] Q_TX_REL    = 6'd40;
    localparam logic [5:0] Q_FER_CHK   = 6'd41;
    localparam logic [5:0] Q_COMMIT    = 6'd42;
    localparam logic [5:0] Q_NAK_END   = 6'd46;
    localparam logic [5:0] Q_RESEND    = 6'd48;

    // status bit positions
    localparam int ST_FT  = 0;
    localparam int ST_FER = 1;
    localparam int ST_OVR = 2;
    localparam int ST_PE  = 3;
    localparam int ST_W   = 4;
endpackage

// File: rtl/sc_fifo.sv
module sc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          rd,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          do_wr;
    logic          do_rd;

    assign full  = (count == CW'(DEPTH));
    assign do_wr = wr && !full;
    assign do_rd = rd && (count != '0);
    assign rdata = mem[rptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= bump(wptr);
            if (do_rd) rptr <= bump(rptr);
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/sc_rx.sv
module sc_rx
    import sc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       qtick,
    input  logic       enable,
    input  logic       io_in,
    input  logic       proto_t1,
    input  logic [2:0] err_limit,
    output logic       drive_low,
    output logic       idle,
    output logic       wr_req,
    output logic [7:0] wr_data,
    output logic       pe_event,
    output logic       fer_event,
    output logic       reject
);
    rx_state_t  state;
    rx_state_t  state_nx;
    logic [5:0] n;
    logic [5:0] nn;
    logic [8:0] sh;
    logic [2:0] errcnt;
    logic [3:0] lim;
    logic [3:0] err_nx;
    logic       perr;
    logic       commit;
    logic       limit_hit;

    assign nn        = n + 6'd1;
    assign perr      = ^sh;
    assign lim       = (err_limit == 3'd0) ? 4'd1 : {1'b0, err_limit};
    assign err_nx    = {1'b0, errcnt} + 4'd1;
    assign limit_hit = (err_nx >= lim);
    assign commit    = (state == RX_STOP) && qtick && (nn == Q_COMMIT);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:  if (qtick && enable && !io_in) state_nx = RX_START;
            RX_START: if (qtick && nn == Q_START_CHK) state_nx = io_in ? RX_IDLE : RX_BITS;
            RX_BITS:  if (qtick && nn == Q_PAR_SMP) state_nx = RX_STOP;
            RX_STOP:  if (commit) state_nx = (!proto_t1 && perr) ? RX_NAK : RX_IDLE;
            RX_NAK:   if (qtick && nn == Q_NAK_END) state_nx = RX_IDLE;
            default:  state_nx = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    // datapath: quarter counter, shifter, retry counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n      <= '0;
            sh     <= '0;
            errcnt <= '0;
        end else begin
            if (state == RX_IDLE) begin
                n <= '0;
            end else if (qtick) begin
                n <= nn;
            end
            if (state == RX_BITS && qtick && nn[1:0] == 2'd2) begin
                sh <= {io_in, sh[8:1]};
            end
            if (commit) begin
                if (proto_t1 || !perr || limit_hit) errcnt <= '0;
                else                                errcnt <= err_nx[2:0];
            end
        end
    end

    // outputs
    always_comb begin
        idle      = (state == RX_IDLE);
        drive_low = (state == RX_NAK);
        wr_data   = sh[7:0];
        wr_req    = commit && (proto_t1 || !perr);
        reject    = commit && !proto_t1 && perr;
        pe_event  = commit && perr && (proto_t1 || limit_hit);
        fer_event = (state == RX_STOP) && qtick && (nn == Q_FER_CHK) && !io_in;
    end
endmodule

// File: rtl/sc_tx.sv
module sc_tx
    import sc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       qtick,
    input  logic       go,
    input  logic       allow,
    input  logic [7:0] data,
    input  logic       io_in,
    input  logic       proto_t1,
    input  logic [2:0] err_limit,
    output logic       drive_low,
    output logic       busy,
    output logic       pe_event
);
    tx_state_t   state;
    tx_state_t   state_nx;
    logic [5:0]  n;
    logic [5:0]  nn;
    logic [15:0] frame;
    logic [2:0]  naks;
    logic        give_up;
    logic        nak_seen;

    assign nn       = n + 6'd1;
    assign nak_seen = (state == TX_GUARD) && qtick && (nn == Q_COMMIT) && !proto_t1 && !io_in;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:  if (go && allow) state_nx = TX_ARM;
            TX_ARM:   if (qtick) state_nx = TX_SEND;
            TX_SEND:  if (qtick && nn == Q_TX_REL) state_nx = TX_GUARD;
            TX_GUARD: if (qtick && nn == Q_COMMIT) state_nx = nak_seen ? TX_HOLD : TX_IDLE;
            TX_HOLD: begin
                if (qtick && give_up && nn == Q_NAK_END)       state_nx = TX_IDLE;
                else if (qtick && !give_up && nn == Q_RESEND) state_nx = TX_SEND;
            end
            default:  state_nx = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n       <= '0;
            frame   <= '1;
            naks    <= '0;
            give_up <= 1'b0;
        end else begin
            if (state == TX_IDLE && go && allow) begin
                frame   <= {6'h3f, ^data, data, 1'b0};
                naks    <= '0;
                give_up <= 1'b0;
            end
            if (state == TX_IDLE || state == TX_ARM || state_nx == TX_SEND && state == TX_HOLD) begin
                n <= '0;
            end else if (qtick) begin
                n <= nn;
            end
            if (nak_seen) begin
                if (naks == err_limit) give_up <= 1'b1;
                else                   naks    <= naks + 3'd1;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state != TX_IDLE);
        drive_low = (state == TX_SEND) && !frame[n[5:2]];
        pe_event  = (state == TX_HOLD) && qtick && give_up && (nn == Q_NAK_END);
    end
endmodule

// File: rtl/sc_char_engine.sv
module sc_char_engine
    import sc_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int THR_W = 5,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qtick,
    input  logic             proto_t1,
    input  logic [2:0]       err_limit,
    input  logic [THR_W-1:0] ft_thr,
    input  logic             io_in,
    output logic             io_low,
    input  logic             tx_go,
    input  logic [7:0]       tx_data,
    output logic             tx_busy,
    input  logic             rd_pop,
    output logic [7:0]       rd_data,
    output logic [CW-1:0]    fifo_count,
    input  logic             stat_rd,
    output logic [ST_W-1:0]  status,
    output logic             irq
);
    logic            rx_drv;
    logic            rx_idle;
    logic            rx_wr;
    logic [7:0]      rx_byte;
    logic            rx_pe;
    logic            rx_fer;
    logic            rx_rej;
    logic            tx_drv;
    logic            tx_pe;
    logic            fifo_full;
    logic            fifo_wr;
    logic [ST_W-1:0] ev;
    logic [ST_W-1:0] flags;

    sc_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .qtick     (qtick),
        .enable    (!tx_busy),
        .io_in     (io_in),
        .proto_t1  (proto_t1),
        .err_limit (err_limit),
        .drive_low (rx_drv),
        .idle      (rx_idle),
        .wr_req    (rx_wr),
        .wr_data   (rx_byte),
        .pe_event  (rx_pe),
        .fer_event (rx_fer),
        .reject    (rx_rej)
    );

    sc_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .qtick     (qtick),
        .go        (tx_go),
        .allow     (rx_idle),
        .data      (tx_data),
        .io_in     (io_in),
        .proto_t1  (proto_t1),
        .err_limit (err_limit),
        .drive_low (tx_drv),
        .busy      (tx_busy),
        .pe_event  (tx_pe)
    );

    sc_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (fifo_wr),
        .wdata (rx_byte),
        .rd    (rd_pop),
        .rdata (rd_data),
        .count (fifo_count),
        .full  (fifo_full)
    );

    assign fifo_wr = rx_wr && !fifo_full;
    assign io_low  = rx_drv || tx_drv;

    always_comb begin
        ev         = '0;
        ev[ST_FT]  = fifo_wr && (int'(fifo_count) == int'(ft_thr));
        ev[ST_FER] = rx_fer;
        ev[ST_OVR] = rx_wr && fifo_full;
        ev[ST_PE]  = rx_pe || tx_pe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (stat_rd ? '0 : flags) | ev;
    end

    assign status = flags;
    assign irq    = |flags;
endmodule

// File: rtl/sc_char_engine_chk.sv
module sc_char_engine_chk #(
    parameter int DEPTH = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          proto_t1,
    input logic          stat_rd,
    input logic          io_low,
    input logic          tx_busy,
    input logic [3:0]    status,
    input logic          irq,
    input logic [CW-1:0] fifo_count,
    input logic [3:0]    ev,
    input logic          fifo_wr,
    input logic          rx_rej
);
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((status & $past(status)) == $past(status)));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && ev == 4'd0) |=> (status == 4'd0));

    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(ev) != 4'd0));

    assert_nak_only_t0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_low && !tx_busy) |-> !proto_t1);

    assert_t0_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rej |-> !fifo_wr);

    assert_ovr_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev[2] |-> (fifo_count == CW'(DEPTH)));

    assert_fifo_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));
endmodule

bind sc_char_engine sc_char_engine_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .proto_t1   (proto_t1),
    .stat_rd    (stat_rd),
    .io_low     (io_low),
    .tx_busy    (tx_busy),
    .status     (status),
    .irq        (irq),
    .fifo_count (fifo_count),
    .ev         (ev),
    .fifo_wr    (fifo_wr),
    .rx_rej     (rx_rej)
);

// File: tb/sc_char_engine_tb_top.sv
module sc_char_engine_tb_top;
    localparam int DEPTH = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          qtick = 1'b0;
    logic          proto_t1 = 1'b1;
    logic [2:0]    err_limit = 3'd2;
    logic [4:0]    ft_thr = 5'd31;
    logic          tx_go = 1'b0;
    logic [7:0]    tx_data = 8'h00;
    logic          rd_pop = 1'b0;
    logic          stat_rd = 1'b0;
    logic          card_lvl = 1'b1;
    logic          mon_en = 1'b0;
    logic          io_in;
    logic          io_low;
    logic          tx_busy;
    logic [7:0]    rd_data;
    logic [CW-1:0] fifo_count;
    logic [3:0]    status;
    logic          irq;
    logic [7:0]    exp_q [$];
    int            total = 0;
    int            bad = 0;
    int            qdiv = 0;

    assign io_in = card_lvl & ~io_low;

    sc_char_engine #(.DEPTH(DEPTH), .THR_W(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .qtick(qtick), .proto_t1(proto_t1),
        .err_limit(err_limit), .ft_thr(ft_thr), .io_in(io_in), .io_low(io_low),
        .tx_go(tx_go), .tx_data(tx_data), .tx_busy(tx_busy), .rd_pop(rd_pop),
        .rd_data(rd_data), .fifo_count(fifo_count), .stat_rd(stat_rd),
        .status(status), .irq(irq)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        qdiv  <= (qdiv + 1) % 4;
        qtick <= (qdiv == 3);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: pops the FIFO and compares with expected queue (R1)
    always @(negedge clk) begin
        rd_pop <= 1'b0;
        if (mon_en && rst_n && fifo_count != '0 && !rd_pop) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected char", int'(rd_data), 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R1 data", int'(rd_data), int'(e));
            end
            rd_pop <= 1'b1;
        end
    end

    task automatic next_q();
        @(posedge clk iff qtick);
        @(negedge clk);
    endtask

    // card drives one character; returns just after commit + refusal window
    task automatic send_char(input logic [7:0] d, input bit badp, input bit ferl, input bit exp_nak);
        next_q();
        card_lvl = 1'b0;
        repeat (4) next_q();
        for (int i = 0; i < 8; i++) begin
            card_lvl = d[i];
            repeat (4) next_q();
        end
        card_lvl = (^d) ^ badp;
        repeat (4) next_q();
        card_lvl = !ferl;
        repeat (2) next_q();
        card_lvl = 1'b1;
        next_q();
        chk(io_low == exp_nak, "R3 refusal pulse level", int'(io_low), int'(exp_nak));
        repeat (4) next_q();
        chk(io_low == 1'b0, "R3 refusal released", int'(io_low), 0);
        repeat (3) next_q();
    endtask

    task automatic drain();
        for (int i = 0; i < 2000; i++) begin
            if (exp_q.size() == 0 && fifo_count == '0) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R1 all expected chars seen", exp_q.size(), 0);
    endtask

    task automatic read_clear(output logic [3:0] s);
        @(negedge clk);
        s = status;
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        chk(status == 4'd0, "R9 cleared by read", int'(status), 0);
        chk(irq == 1'b0, "R10 irq low with no flags", int'(irq), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [3:0] s;
        int pos;
        logic [7:0] d;
        logic e;

        repeat (5) @(negedge clk);
        chk(status == 4'd0, "R9 reset flags", int'(status), 0);
        chk(irq == 1'b0, "R10 reset irq", int'(irq), 0);
        chk(fifo_count == '0, "R1 reset fifo empty", int'(fifo_count), 0);
        chk(io_low == 1'b0 && tx_busy == 1'b0, "R11 reset idle line", int'({io_low, tx_busy}), 0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        mon_en = 1'b1;

        // R1: T=1 good characters
        proto_t1 = 1'b1;
        exp_q.push_back(8'hA5); send_char(8'hA5, 0, 0, 0);
        exp_q.push_back(8'h3C); send_char(8'h3C, 0, 0, 0);
        drain();
        chk(status == 4'd0, "R1 no flags on good chars", int'(status), 0);

        // R2: start glitch
        next_q(); card_lvl = 1'b0; next_q(); card_lvl = 1'b1;
        repeat (60) next_q();
        chk(fifo_count == '0, "R2 glitch stores nothing", int'(fifo_count), 0);
        chk(status == 4'd0, "R2 glitch sets no flag", int'(status), 0);

        // R5: T=1 bad parity stored and flagged
        exp_q.push_back(8'h5A); send_char(8'h5A, 1, 0, 0);
        chk(status[3] == 1'b1, "R5 parity flag in T1", int'(status), 8);
        chk(irq == 1'b1, "R10 irq with flag", int'(irq), 1);
        drain();
        read_clear(s);
        chk(s == 4'b1000, "R9 read value", int'(s), 8);

        // R3/R4: T=0 refusals and retry count
        proto_t1 = 1'b0; err_limit = 3'd2;
        send_char(8'h11, 1, 0, 1);
        chk(fifo_count == '0, "R3 bad char not stored", int'(fifo_count), 0);
        chk(status[3] == 1'b0, "R4 first failure no flag", int'(status), 0);
        send_char(8'h11, 1, 0, 1);
        chk(status[3] == 1'b1, "R4 flag at limit", int'(status), 8);
        read_clear(s);
        send_char(8'h22, 1, 0, 1);
        exp_q.push_back(8'h66); send_char(8'h66, 0, 0, 0);
        send_char(8'h22, 1, 0, 1);
        chk(status[3] == 1'b0, "R4 count cleared by good char", int'(status), 0);
        drain();

        // R6: framing error
        exp_q.push_back(8'h42); send_char(8'h42, 0, 1, 0);
        chk(status == 4'b0010, "R6 framing flag", int'(status), 2);
        drain();
        read_clear(s);

        // R7/R8: threshold and overrun
        mon_en = 1'b0; ft_thr = 5'd1;
        send_char(8'h01, 0, 0, 0);
        chk(status[0] == 1'b0, "R7 no threshold at count 1", int'(status), 0);
        send_char(8'h02, 0, 0, 0);
        chk(status[0] == 1'b1, "R7 threshold at count 2", int'(status), 1);
        read_clear(s);
        send_char(8'h03, 0, 0, 0);
        send_char(8'h04, 0, 0, 0);
        chk(status == 4'd0, "R8 no overrun while room", int'(status), 0);
        send_char(8'h05, 0, 0, 0);
        chk(status[2] == 1'b1, "R8 overrun flag", int'(status), 4);
        chk(fifo_count == CW'(DEPTH), "R8 count stays at depth", int'(fifo_count), DEPTH);
        exp_q.push_back(8'h01); exp_q.push_back(8'h02);
        exp_q.push_back(8'h03); exp_q.push_back(8'h04);
        mon_en = 1'b1; ft_thr = 5'd31;
        drain();
        read_clear(s);

        // R11/R13: T=0 transmit, no refusal
        err_limit = 3'd1;
        d = 8'hC3;
        next_q(); tx_data = d; tx_go = 1'b1; @(negedge clk); tx_go = 1'b0;
        pos = 0;
        for (int k = 0; k < 10; k++) begin
            repeat (4 * k + 3 - pos) next_q();
            pos = 4 * k + 3;
            e = (k == 0) ? 1'b1 : (k < 9) ? !d[k-1] : !(^d);
            chk(io_low == e, "R11 frame bit", int'(io_low), int'(e));
        end
        repeat (43 - pos) next_q();
        chk(tx_busy == 1'b0, "R11 done at 10.5 ETU", int'(tx_busy), 0);
        chk(status == 4'd0, "R11 no flag without refusal", int'(status), 0);
        chk(fifo_count == '0, "R13 own frame not received", int'(fifo_count), 0);

        // R12: two refusals with limit 1
        next_q(); tx_data = 8'h9E; tx_go = 1'b1; @(negedge clk); tx_go = 1'b0;
        repeat (42) next_q(); card_lvl = 1'b0;
        repeat (4) next_q(); card_lvl = 1'b1;
        next_q();
        chk(status[3] == 1'b0, "R12 first refusal no flag", int'(status), 0);
        chk(tx_busy == 1'b1, "R12 busy during retry", int'(tx_busy), 1);
        repeat (4) next_q();
        chk(io_low == 1'b1, "R12 resend start bit", int'(io_low), 1);
        repeat (39) next_q(); card_lvl = 1'b0;
        repeat (4) next_q(); card_lvl = 1'b1;
        chk(status[3] == 1'b0, "R12 flag not before 11.5 ETU", int'(status), 0);
        next_q();
        chk(status[3] == 1'b1, "R12 flag after last refusal", int'(status), 8);
        chk(tx_busy == 1'b0, "R12 gives up", int'(tx_busy), 0);
        chk(irq == 1'b1, "R10 irq from transmit flag", int'(irq), 1);
        repeat (4) next_q();
        chk(fifo_count == '0, "R13 refusals not received", int'(fifo_count), 0);
        read_clear(s);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule